// File: doc/BRIEF.md
# Instruction Exception Check Unit

This unit sits in the decode stage of a compact core with 16-bit instructions and decides whether the instruction now being decoded must trap instead of executing. Three conditions are checked in parallel:
- an instruction the main decoder has marked as forbidden in a branch delay slot appears in one;
- an instruction marked as privileged is issued in user mode;
- a floating-point instruction is issued while the status register's FP-disable bit is set.

Floating-point instructions include the ordinary FP arithmetic class and the moves to and from the FP status and FP communication registers.

For each valid instruction the unit registers one verdict on the next clock edge. Either a trap strobe appears, with a 12-bit exception code and the PC to save, or a commit enable appears. The commit enable carries the per-form permission for the register adjust of the post-increment and pre-decrement memory forms. When the instruction reads the FP status register and is allowed to run, the unit also returns that register's value with its reserved upper bits forced to zero. A trap withholds every side effect of the instruction.

Top module: `excCheckUnit`

## Requirements
- R1: After reset, and in the cycle after any cycle with `instValid` low, every output is zero. Otherwise the outputs reflect the instruction sampled at the previous rising clock edge.
- R2: An instruction is FP-gated if its bits 15:12 equal 0xF, or if the pair {bits 15:12, bits 7:0} is one of 4/6A, 4/66, 0/6A, 4/62, 4/5A, 4/56, 0/5A or 4/52. Bits 11:8 are ignored. A gated instruction traps when bit 15 of `statusReg` is 1.
- R3: An FP-disable trap outside a delay slot gives code 0x800 and saves `pc` unchanged.
- R4: An FP-disable trap inside a delay slot (`slotUncond` or `slotCond` high) gives code 0x820 and saves `pc` minus 2, modulo 2^32.
- R5: `slotForbidden` high inside a delay slot traps with code 0x1A0 and saves `pc` minus 2.
- R6: `privOp` high with `userMode` high traps with code 0x180 and saves `pc`.
- R7: When several checks fire together, slot-illegal wins over privileged, and privileged wins over FP-disable.
- R8: Without a trap, `trapValid`, `trapCode` and `trapPc` are zero. A gated instruction with bit 15 of `statusReg` clear does not trap.
- R9: `adjInc` is high for an untrapped 4/66 or 4/56 form, and `adjDec` is high for an untrapped 4/62 or 4/52 form. A trap forces both low.
- R10: For an untrapped 0/6A or 4/62 form, `fpsRdValid` is 1 and `fpsRdData` equals `fpStatus` AND 0x003FFFFF. Otherwise both are zero.
- R11: After a valid instruction, exactly one of `trapValid` and `commitEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | An instruction is presented this cycle |
| opcode | input | 16 | Instruction word |
| pc | input | 32 | Address of the instruction |
| slotUncond | input | 1 | Instruction sits in an unconditional branch's delay slot |
| slotCond | input | 1 | Instruction sits in a conditional branch's delay slot |
| slotForbidden | input | 1 | Main decoder: instruction is not allowed in a delay slot |
| userMode | input | 1 | Core is in user mode |
| privOp | input | 1 | Main decoder: instruction is privileged |
| statusReg | input | 32 | Status register; bit 15 disables the FPU |
| fpStatus | input | 32 | Current FP status register value |
| trapValid | output | 1 | The instruction traps |
| trapCode | output | 12 | Exception code |
| trapPc | output | 32 | PC to save for the handler |
| commitEn | output | 1 | The instruction may write back |
| adjInc | output | 1 | Post-increment of Rm permitted |
| adjDec | output | 1 | Pre-decrement of Rn permitted |
| fpsRdValid | output | 1 | FP status read data is valid |
| fpsRdData | output | 32 | Masked FP status value |

## Verification
On every cycle, the assertions check the following:
- the split between trap and commit;
- the absence of side effects on a trap;
- the masked upper bits of the read data;
- the quiet outputs after an idle cycle;
- the codes and saved PCs for the slot-illegal, privileged and FP-arithmetic cases.

Only the bench scenarios show the rest. These include the full list of gated system-register forms with arbitrary register fields, swept over both delay-slot kinds and both FP-disable settings, and the wrap of the saved PC at address zero. They also cover exact masked read values and three-way priority collisions under random mixes.

// File: rtl/excPkg.sv
package excPkg;
  typedef enum logic [1:0] {
    SEL_SLOT_ILL = 2'd0,
    SEL_PRIV     = 2'd1,
    SEL_FPU      = 2'd2,
    SEL_FPU_SLOT = 2'd3
  } codeSel_e;

  // decoded facts about the current opcode
  typedef struct packed {
    logic fpGated;
    logic incRm;
    logic decRn;
    logic fpsRead;
  } opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     fire;
    logic     trap;
    codeSel_e codeSel;
    logic     backUp;
    logic     commit;
    logic     incRm;
    logic     decRn;
    logic     fpsRead;
  } ctrlStrb_t;
endpackage

// File: rtl/excClassify.sv
module excClassify
  import excPkg::*;
#(
  parameter logic [3:0] FP_NIB = 4'hF
) (
  input  logic [3:0] opHi,
  input  logic [7:0] opLo,
  output opClass_t   cls
);
  localparam int N_GATED = 8;
  // {bits 15:12, bits 7:0} of each gated system-register transfer
  localparam logic [11:0] GATED_PAT [N_GATED] = '{
    12'h46A, 12'h466, 12'h06A, 12'h462,
    12'h45A, 12'h456, 12'h05A, 12'h452
  };
  localparam int IDX_FPS_LD_MEM  = 1;
  localparam int IDX_FPS_ST_REG  = 2;
  localparam int IDX_FPS_ST_MEM  = 3;
  localparam int IDX_FPUL_LD_MEM = 5;
  localparam int IDX_FPUL_ST_MEM = 7;

  logic [N_GATED-1:0] patHit;
  logic               fpArith;

  for (genvar g = 0; g < N_GATED; g++) begin : gPat
    assign patHit[g] = ({opHi, opLo} == GATED_PAT[g]);
  end

  assign fpArith = (opHi == FP_NIB);

  always_comb begin
    cls.fpGated = fpArith | (|patHit);
    cls.incRm   = patHit[IDX_FPS_LD_MEM] | patHit[IDX_FPUL_LD_MEM];
    cls.decRn   = patHit[IDX_FPS_ST_MEM] | patHit[IDX_FPUL_ST_MEM];
    cls.fpsRead = patHit[IDX_FPS_ST_REG] | patHit[IDX_FPS_ST_MEM];
  end
endmodule

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
(
  input  logic      instValid,
  input  opClass_t  cls,
  input  logic      slotUncond,
  input  logic      slotCond,
  input  logic      slotForbidden,
  input  logic      userMode,
  input  logic      privOp,
  input  logic      fdSet,
  output ctrlStrb_t strb
);
  logic inSlot;
  logic slotHit;
  logic privHit;
  logic fpuHit;
  logic anyTrap;

  assign inSlot  = slotUncond | slotCond;
  assign slotHit = inSlot & slotForbidden;
  assign privHit = userMode & privOp;
  assign fpuHit  = fdSet & cls.fpGated;
  assign anyTrap = slotHit | privHit | fpuHit;

  always_comb begin
    strb.fire    = instValid;
    strb.trap    = anyTrap;
    strb.codeSel = SEL_FPU;
    strb.backUp  = 1'b0;
    if (slotHit) begin
      strb.codeSel = SEL_SLOT_ILL;
      strb.backUp  = 1'b1;
    end else if (privHit) begin
      strb.codeSel = SEL_PRIV;
    end else if (fpuHit) begin
      strb.codeSel = inSlot ? SEL_FPU_SLOT : SEL_FPU;
      strb.backUp  = inSlot;
    end
    strb.commit  = ~anyTrap;
    strb.incRm   = cls.incRm & ~anyTrap;
    strb.decRn   = cls.decRn & ~anyTrap;
    strb.fpsRead = cls.fpsRead & ~anyTrap;
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          CODE_W     = 12,
  parameter int          FPS_W      = 32,
  parameter int          SLOT_BACK  = 2,
  parameter logic [31:0] FPS_MASK   = 32'h003F_FFFF,
  parameter logic [11:0] CODE_FPU   = 12'h800,
  parameter logic [11:0] CODE_FPU_S = 12'h820,
  parameter logic [11:0] CODE_ILL   = 12'h180,
  parameter logic [11:0] CODE_ILL_S = 12'h1A0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [PC_W-1:0]   pc,
  input  logic [FPS_W-1:0]  fpStatus,
  output logic              trapValid,
  output logic [CODE_W-1:0] trapCode,
  output logic [PC_W-1:0]   trapPc,
  output logic              commitEn,
  output logic              adjInc,
  output logic              adjDec,
  output logic              fpsRdValid,
  output logic [FPS_W-1:0]  fpsRdData
);
  localparam logic [PC_W-1:0]  BACK_STEP = PC_W'(SLOT_BACK);
  localparam logic [FPS_W-1:0] MASK_W    = FPS_W'(FPS_MASK);

  logic [CODE_W-1:0] codeNext;
  logic [PC_W-1:0]   pcNext;

  always_comb begin
    unique case (strb.codeSel)
      SEL_SLOT_ILL: codeNext = CODE_W'(CODE_ILL_S);
      SEL_PRIV:     codeNext = CODE_W'(CODE_ILL);
      SEL_FPU_SLOT: codeNext = CODE_W'(CODE_FPU_S);
      default:      codeNext = CODE_W'(CODE_FPU);
    endcase
    pcNext = strb.backUp ? (pc - BACK_STEP) : pc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapValid  <= 1'b0;
      trapCode   <= '0;
      trapPc     <= '0;
      commitEn   <= 1'b0;
      adjInc     <= 1'b0;
      adjDec     <= 1'b0;
      fpsRdValid <= 1'b0;
      fpsRdData  <= '0;
    end else if (strb.fire) begin
      trapValid  <= strb.trap;
      trapCode   <= strb.trap ? codeNext : '0;
      trapPc     <= strb.trap ? pcNext : '0;
      commitEn   <= strb.commit;
      adjInc     <= strb.incRm;
      adjDec     <= strb.decRn;
      fpsRdValid <= strb.fpsRead;
      fpsRdData  <= strb.fpsRead ? (fpStatus & MASK_W) : '0;
    end else begin
      trapValid  <= 1'b0;
      trapCode   <= '0;
      trapPc     <= '0;
      commitEn   <= 1'b0;
      adjInc     <= 1'b0;
      adjDec     <= 1'b0;
      fpsRdValid <= 1'b0;
      fpsRdData  <= '0;
    end
  end
endmodule

// File: rtl/excCheckUnit.sv
module excCheckUnit
  import excPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int SR_W   = 32,
  parameter int FPS_W  = 32,
  parameter int CODE_W = 12,
  parameter int FD_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       opcode,
  input  logic [PC_W-1:0]   pc,
  input  logic              slotUncond,
  input  logic              slotCond,
  input  logic              slotForbidden,
  input  logic              userMode,
  input  logic              privOp,
  input  logic [SR_W-1:0]   statusReg,
  input  logic [FPS_W-1:0]  fpStatus,
  output logic              trapValid,
  output logic [CODE_W-1:0] trapCode,
  output logic [PC_W-1:0]   trapPc,
  output logic              commitEn,
  output logic              adjInc,
  output logic              adjDec,
  output logic              fpsRdValid,
  output logic [FPS_W-1:0]  fpsRdData
);
  opClass_t  cls;
  ctrlStrb_t strb;
  logic      unusedBits;

  // register field and the other status bits play no part here
  assign unusedBits = ^{opcode[11:8], statusReg[SR_W-1:FD_BIT+1], statusReg[FD_BIT-1:0]};

  excClassify uClassify (
    .opHi (opcode[15:12]),
    .opLo (opcode[7:0]),
    .cls  (cls)
  );

  excControl uControl (
    .instValid     (instValid),
    .cls           (cls),
    .slotUncond    (slotUncond),
    .slotCond      (slotCond),
    .slotForbidden (slotForbidden),
    .userMode      (userMode),
    .privOp        (privOp),
    .fdSet         (statusReg[FD_BIT]),
    .strb          (strb)
  );

  excDatapath #(
    .PC_W   (PC_W),
    .CODE_W (CODE_W),
    .FPS_W  (FPS_W)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pc         (pc),
    .fpStatus   (fpStatus),
    .trapValid  (trapValid),
    .trapCode   (trapCode),
    .trapPc     (trapPc),
    .commitEn   (commitEn),
    .adjInc     (adjInc),
    .adjDec     (adjDec),
    .fpsRdValid (fpsRdValid),
    .fpsRdData  (fpsRdData)
  );
endmodule

// File: rtl/excCheckSva.sv
module excCheckSva (
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [3:0]  opTop,
  input logic [31:0] pc,
  input logic        slotUncond,
  input logic        slotCond,
  input logic        slotForbidden,
  input logic        userMode,
  input logic        privOp,
  input logic        fdBit,
  input logic        trapValid,
  input logic [11:0] trapCode,
  input logic [31:0] trapPc,
  input logic        commitEn,
  input logic        adjInc,
  input logic        adjDec,
  input logic        fpsRdValid,
  input logic [31:0] fpsRdData
);
  logic inSlot;
  assign inSlot = slotUncond | slotCond;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> (!trapValid && !commitEn && !adjInc && !adjDec && !fpsRdValid));

  p_fpu_plain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && fdBit && opTop == 4'hF && !inSlot && !(userMode && privOp))
    |=> (trapValid && trapCode == 12'h800 && trapPc == $past(pc)));

  p_fpu_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && fdBit && opTop == 4'hF && inSlot && !slotForbidden && !(userMode && privOp))
    |=> (trapValid && trapCode == 12'h820 && trapPc == $past(pc) - 32'd2));

  p_slot_ill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && inSlot && slotForbidden)
    |=> (trapValid && trapCode == 12'h1A0 && trapPc == $past(pc) - 32'd2));

  p_priv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !(inSlot && slotForbidden) && userMode && privOp)
    |=> (trapValid && trapCode == 12'h180 && trapPc == $past(pc)));

  p_no_effect_r9: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (!adjInc && !adjDec && !fpsRdValid));

  p_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    fpsRdData[31:22] == 10'd0);

  p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> $countones({trapValid, commitEn}) == 1);
endmodule

bind excCheckUnit excCheckSva uSva (
  .clk           (clk),
  .rstN          (rstN),
  .instValid     (instValid),
  .opTop         (opcode[15:12]),
  .pc            (pc),
  .slotUncond    (slotUncond),
  .slotCond      (slotCond),
  .slotForbidden (slotForbidden),
  .userMode      (userMode),
  .privOp        (privOp),
  .fdBit         (statusReg[15]),
  .trapValid     (trapValid),
  .trapCode      (trapCode),
  .trapPc        (trapPc),
  .commitEn      (commitEn),
  .adjInc        (adjInc),
  .adjDec        (adjDec),
  .fpsRdValid    (fpsRdValid),
  .fpsRdData     (fpsRdData)
);

// File: tb/tb_excCheckUnit.sv
`timescale 1ns/1ps
module tb_excCheckUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] pc = '0;
  logic        slotUncond = 1'b0, slotCond = 1'b0, slotForbidden = 1'b0;
  logic        userMode = 1'b0, privOp = 1'b0;
  logic [31:0] statusReg = '0, fpStatus = '0;
  logic        trapValid, commitEn, adjInc, adjDec, fpsRdValid;
  logic [11:0] trapCode;
  logic [31:0] trapPc, fpsRdData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  excCheckUnit dut (.*);

  localparam logic [11:0] GATED [8] = '{12'h46A, 12'h466, 12'h06A, 12'h462,
                                        12'h45A, 12'h456, 12'h05A, 12'h452};

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isGated(logic [15:0] op);
    if (op[15:12] == 4'hF) return 1'b1;
    foreach (GATED[i]) if ({op[15:12], op[7:0]} == GATED[i]) return 1'b1;
    return 1'b0;
  endfunction

  // apply one instruction at a falling edge, compare at the next falling edge
  task automatic runOne(logic [15:0] op, logic [31:0] addr, logic su, logic sc,
                        logic sf, logic um, logic po, logic fd, logic [31:0] fps,
                        string codeTag);
    bit inSlot, sHit, pHit, fHit, trap, isInc, isDec, isRd;
    logic [11:0] eCode;
    logic [31:0] ePc;
    logic [11:0] key;
    opcode = op; pc = addr; slotUncond = su; slotCond = sc; slotForbidden = sf;
    userMode = um; privOp = po; fpStatus = fps;
    statusReg = $urandom; statusReg[15] = fd;
    instValid = 1'b1;
    @(negedge clk);
    key = {op[15:12], op[7:0]};
    inSlot = su | sc;
    sHit = inSlot && sf;
    pHit = um && po;
    fHit = fd && isGated(op);
    trap = sHit || pHit || fHit;
    eCode = 12'h0; ePc = 32'h0;
    if (sHit) begin eCode = 12'h1A0; ePc = addr - 32'd2; end
    else if (pHit) begin eCode = 12'h180; ePc = addr; end
    else if (fHit) begin eCode = inSlot ? 12'h820 : 12'h800; ePc = inSlot ? addr - 32'd2 : addr; end
    isInc = (key == 12'h466) || (key == 12'h456);
    isDec = (key == 12'h462) || (key == 12'h452);
    isRd  = (key == 12'h06A) || (key == 12'h462);
    check("R2", "trapValid", 32'(trapValid), 32'(trap));
    check(codeTag, "trapCode", 32'(trapCode), 32'(eCode));
    check(codeTag, "trapPc", trapPc, ePc);
    check("R11", "commitEn", 32'(commitEn), 32'(!trap));
    check("R9", "adjInc", 32'(adjInc), 32'(isInc && !trap));
    check("R9", "adjDec", 32'(adjDec), 32'(isDec && !trap));
    check("R10", "fpsRdValid", 32'(fpsRdValid), 32'(isRd && !trap));
    check("R10", "fpsRdData", fpsRdData, (isRd && !trap) ? (fps & 32'h003F_FFFF) : 32'h0);
  endtask

  task automatic checkQuiet(string req);
    check(req, "quiet outputs",
          32'({trapValid, commitEn, adjInc, adjDec, fpsRdValid, |trapCode, |trapPc, |fpsRdData}),
          32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checkQuiet("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R1");

    // every gated transfer, three slot states, both FP-disable settings
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 3; s++)
        for (int fd = 0; fd < 2; fd++) begin
          logic [15:0] op;
          op = {GATED[p][11:8], 4'($urandom), GATED[p][7:0]};
          runOne(op, {$urandom} & 32'hFFFF_FFFE, s == 1, s == 2, 1'b0, 1'b0, 1'b0,
                 fd[0], $urandom, fd == 0 ? "R8" : (s == 0 ? "R3" : "R4"));
        end

    // directed corners
    runOne(16'hF00C, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, "R4"); // wrap
    runOne(16'hF123, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, "R3");
    runOne(16'h002B, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R5");
    runOne(16'h002B, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, "R6");
    runOne(16'h406A, 32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0, "R7");
    runOne(16'h406A, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, "R7");
    runOne(16'h006A, 32'h0000_6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, "R10");
    runOne(16'h3456, 32'h0000_7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, "R8");
    instValid = 1'b0;
    @(negedge clk);
    checkQuiet("R1");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] op;
      int pick;
      pick = $urandom_range(0, 3);
      if (pick < 2) op = {GATED[$urandom_range(0, 7)][11:8], 4'($urandom), GATED[$urandom_range(0, 7)][7:0]};
      else if (pick == 2) op = {4'hF, 12'($urandom)};
      else op = 16'($urandom);
      runOne(op, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), $urandom, "R7");
    end
    instValid = 1'b0;
    @(negedge clk);
    checkQuiet("R1");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule